// File: doc/BRIEF.md
# H-Bridge Diagonal Test-Cycle Gate Sequencer

This block drives the two switches of one diagonal pair in an H-bridge. The load is inductive, so the gate pattern produces a triangular test current that repeats. Each switching period has three phases:

- **Ramp-up:** both switches conduct and the current rises.
- **Ramp-down:** both gates are released. The current decays through the freewheeling diodes of the opposite pair.
- **Zero-current interval:** switch A alone is turned back on and a small sensing current is enabled, so that the on-state voltage can be measured at low current.

The pattern is open loop and fixed in duty. It repeats for as long as the enable input is high.

Two single-cycle strobes mark the acquisition instants:

- One fires on the turn-off edge at the ramp peak. It triggers the high-current sample.
- One fires on the turn-on that begins each following ramp. It tells the acquisition side to store the sensing-current samples just collected.

The three phase lengths are given in clock cycles. They are sampled only when a ramp-up begins, so the cycle in progress is never cut short.

Top module: `hbridge_test_seq`

## Requirements
- R1: While `rst` is high, or on the first clock after `en` is seen low, every output is low and the sequence returns to its idle state. The next clock with `en` high begins a fresh ramp-up, and that first ramp-up carries no restart strobe.
- R2: Ramp-up lasts max(`up_len`,1) cycles, with `gate_a` and `gate_b` both high. It begins on the first clock edge at which `en` is sampled high from idle.
- R3: Ramp-down follows and lasts max(`down_len`,1) cycles, with both gates and `sense_en` low.
- R4: The zero-current interval follows and lasts max(`zero_len`,2) cycles. In every cycle but its last, `gate_a` and `sense_en` are high and `gate_b` is low. In its last cycle all three are low.
- R5: `peak_strobe` is high for exactly the first ramp-down cycle, which is the cycle in which both gates have just turned off.
- R6: `restart_strobe` is high for exactly the first cycle of every ramp-up that follows a zero-current interval.
- R7: The phases repeat in the fixed order ramp-up, ramp-down, zero-current. The period is the sum of the three effective lengths and no other input affects it.
- R8: The three length inputs are captured only on the clock edge that starts a ramp-up. A change at any other time takes effect from the next period.
- R9: When `en` is low, `gate_a`, `gate_b` and `sense_en` are low in that same cycle, without waiting for a clock edge.
- R10: `sense_en` is low in the cycle before either gate rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces all gates off |
| up_len | input | CNT_W | Ramp-up length in cycles |
| down_len | input | CNT_W | Ramp-down length in cycles |
| zero_len | input | CNT_W | Zero-current interval length in cycles |
| gate_a | output | 1 | Gate of the diagonal switch that also carries the sensing current |
| gate_b | output | 1 | Gate of the other diagonal switch |
| sense_en | output | 1 | Sensing-current source enable |
| peak_strobe | output | 1 | Single-cycle trigger at the ramp-peak turn-off |
| restart_strobe | output | 1 | Single-cycle trigger at the turn-on that starts the next ramp |

## Verification
The bench builds the block with `CNT_W` = 4. With that width, every phase length, including 0 and 1, fits into periods of a few cycles. The clamps to one cycle for the ramps and two cycles for the zero interval are therefore exercised directly, and several full periods fit into each vector. The short periods also make it cheap to drop `en` or apply reset inside each phase. They also make it cheap to change the lengths in mid-period and observe which period picks up the new values.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DOWN = 2'd2,
        PH_ZERO = 2'd3
    } phase_t;

    localparam int unsigned RAMP_MIN = 1;
    localparam int unsigned ZERO_MIN = 2;

    function automatic logic [31:0] floor_len(input logic [31:0] v, input int unsigned m);
        return (v < m) ? m : v;
    endfunction

endpackage

// File: rtl/hbs_len_latch.sv
module hbs_len_latch #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] down_in,
    input  logic [CNT_W-1:0] zero_in,
    output logic [CNT_W-1:0] down_q,
    output logic [CNT_W-1:0] zero_q
);
    import hbs_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            down_q <= CNT_W'(RAMP_MIN);
            zero_q <= CNT_W'(ZERO_MIN);
        end else if (load) begin
            down_q <= CNT_W'(floor_len(32'(down_in), RAMP_MIN));
            zero_q <= CNT_W'(floor_len(32'(zero_in), ZERO_MIN));
        end
    end

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst)) |-> ($stable(down_q) && $stable(zero_q))); // R8

endmodule

// File: rtl/hbs_phase_fsm.sv
module hbs_phase_fsm #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] up_in,
    input  logic [CNT_W-1:0] down_q,
    input  logic [CNT_W-1:0] zero_q,
    output hbs_pkg::phase_t  phase,
    output logic             last,
    output logic             load
);
    import hbs_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] up_eff;

    assign up_eff = CNT_W'(floor_len(32'(up_in), RAMP_MIN));
    assign last   = (cnt == '0);
    assign load   = en && !rst && ((phase == PH_IDLE) || (phase == PH_ZERO && last));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    phase <= PH_UP;
                    cnt   <= up_eff - CNT_W'(1);
                end
                PH_UP: begin
                    if (last) begin
                        phase <= PH_DOWN;
                        cnt   <= down_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_DOWN: begin
                    if (last) begin
                        phase <= PH_ZERO;
                        cnt   <= zero_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_ZERO: begin
                    if (last) begin
                        phase <= PH_UP;
                        cnt   <= up_eff - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase) && phase != PH_IDLE) |->
            ((phase == PH_UP   && ($past(phase) == PH_IDLE || $past(phase) == PH_ZERO)) ||
             (phase == PH_DOWN &&  $past(phase) == PH_UP) ||
             (phase == PH_ZERO &&  $past(phase) == PH_DOWN))); // R7

endmodule

// File: rtl/hbs_out_decode.sv
module hbs_out_decode (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  hbs_pkg::phase_t phase,
    input  logic            last,
    output logic            gate_a,
    output logic            gate_b,
    output logic            sense_en,
    output logic            peak_strobe,
    output logic            restart_strobe
);
    import hbs_pkg::*;

    phase_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PH_IDLE;
        else     prev_q <= phase;
    end

    logic zero_open;
    assign zero_open = (phase == PH_ZERO) && !last;

    assign gate_a         = en && ((phase == PH_UP) || zero_open);
    assign gate_b         = en &&  (phase == PH_UP);
    assign sense_en       = en && zero_open;
    assign peak_strobe    = en && (phase == PH_DOWN) && (prev_q == PH_UP);
    assign restart_strobe = en && (phase == PH_UP)   && (prev_q == PH_ZERO);

    AST_PEAK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        peak_strobe |=> !peak_strobe); // R5
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
        restart_strobe |=> !restart_strobe); // R6

endmodule

// File: rtl/hbridge_test_seq.sv
module hbridge_test_seq #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] up_len,
    input  logic [CNT_W-1:0] down_len,
    input  logic [CNT_W-1:0] zero_len,
    output logic             gate_a,
    output logic             gate_b,
    output logic             sense_en,
    output logic             peak_strobe,
    output logic             restart_strobe
);
    import hbs_pkg::*;

    phase_t           phase;
    logic             last;
    logic             load;
    logic [CNT_W-1:0] down_q;
    logic [CNT_W-1:0] zero_q;

    hbs_len_latch #(.CNT_W(CNT_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .down_in (down_len),
        .zero_in (zero_len),
        .down_q  (down_q),
        .zero_q  (zero_q)
    );

    hbs_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .up_in  (up_len),
        .down_q (down_q),
        .zero_q (zero_q),
        .phase  (phase),
        .last   (last),
        .load   (load)
    );

    hbs_out_decode u_dec (
        .clk            (clk),
        .rst            (rst),
        .en             (en),
        .phase          (phase),
        .last           (last),
        .gate_a         (gate_a),
        .gate_b         (gate_b),
        .sense_en       (sense_en),
        .peak_strobe    (peak_strobe),
        .restart_strobe (restart_strobe)
    );

    AST_SENSE_GAP: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_a) || $rose(gate_b)) |-> !$past(sense_en)); // R10
    AST_SENSE_ONE_SW: assert property (@(posedge clk) disable iff (rst)
        sense_en |-> (gate_a && !gate_b)); // R4
    AST_PEAK_AT_TURNOFF: assert property (@(posedge clk) disable iff (rst)
        peak_strobe |-> ($past(gate_b) && !gate_b && !gate_a)); // R5
    AST_RESTART_AT_TURNON: assert property (@(posedge clk) disable iff (rst)
        restart_strobe |-> (gate_b && !$past(gate_b) && !$past(sense_en))); // R6
    AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> !(gate_a || gate_b || sense_en)); // R9

endmodule

// File: tb/tb_hbridge_test_seq.sv
module tb_hbridge_test_seq;

    localparam int unsigned CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en  = 1'b0;
    logic [CNT_W-1:0] up_len   = '0;
    logic [CNT_W-1:0] down_len = '0;
    logic [CNT_W-1:0] zero_len = '0;
    logic gate_a, gate_b, sense_en, peak_strobe, restart_strobe;

    int n_checks = 0;
    int n_fail   = 0;
    logic prev_s = 1'b0;
    logic prev_b = 1'b0;
    logic prev_a = 1'b0;

    always #4 clk = ~clk;

    hbridge_test_seq #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .en(en),
        .up_len(up_len), .down_len(down_len), .zero_len(zero_len),
        .gate_a(gate_a), .gate_b(gate_b), .sense_en(sense_en),
        .peak_strobe(peak_strobe), .restart_strobe(restart_strobe)
    );

    // vector: {up, down, zero}
    localparam int NVEC = 5;
    localparam logic [11:0] VEC [NVEC] = '{
        {4'd3, 4'd2, 4'd4},
        {4'd1, 4'd1, 4'd2},
        {4'd5, 4'd3, 4'd3},
        {4'd0, 4'd0, 4'd0},
        {4'd2, 4'd4, 4'd1}
    };

    function automatic int eff(input int v, input int m);
        return (v < m) ? m : v;
    endfunction

    task automatic chk(input logic [4:0] got, input logic [4:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {a,b,s,pk,rs} actual=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic gap_check();
        if ((gate_b && !prev_b) || (gate_a && !prev_a)) begin
            n_checks++;
            if (prev_s) begin
                n_fail++;
                $display("FAIL R10: sense_en actual=1 expected=0 before gate rise at %0t", $time);
            end
        end
        prev_s = sense_en; prev_b = gate_b; prev_a = gate_a;
    endtask

    // one period of checks, each sample 2 ns after the rising edge
    task automatic run_period(input int u, input int d, input int z, input bit nf,
                              input bit chg, input logic [11:0] nv);
        int eu, ed, ez;
        eu = eff(u, 1); ed = eff(d, 1); ez = eff(z, 2);
        for (int t = 0; t < eu + ed + ez; t++) begin
            logic [4:0] e;
            string r;
            @(posedge clk); #2;
            if (t < eu) begin
                e = {1'b1, 1'b1, 1'b0, 1'b0, (nf && t == 0)}; r = "R2/R6";
            end else if (t < eu + ed) begin
                e = {1'b0, 1'b0, 1'b0, (t == eu), 1'b0}; r = "R3/R5";
            end else if (t < eu + ed + ez - 1) begin
                e = 5'b10100; r = "R4";
            end else begin
                e = 5'b00000; r = "R4/R7";
            end
            chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, e, r);
            gap_check();
            if (chg && t == 1) begin
                up_len = nv[11:8]; down_len = nv[7:4]; zero_len = nv[3:0];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; en = 1'b0;
        @(posedge clk); #2;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b0, "R1");
        prev_s = 0; prev_b = 0; prev_a = 0;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        do_reset();

        // table walk: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] v;
            v = VEC[i];
            do_reset();
            up_len = v[11:8]; down_len = v[7:4]; zero_len = v[3:0];
            en = 1'b1;
            for (int p = 0; p < 3; p++)
                run_period(v[11:8], v[7:4], v[3:0], (p != 0), 1'b0, 12'h0);
            @(negedge clk); en = 1'b0;
        end

        // R9: en drop acts in the same cycle; R1: fresh restart after
        do_reset();
        up_len = 4'd3; down_len = 4'd2; zero_len = 4'd4;
        en = 1'b1;
        @(posedge clk); #2;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b11000, "R2");
        @(negedge clk); en = 1'b0; #1;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b00000, "R9");
        @(posedge clk); #2;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b00000, "R1");
        prev_s = 0; prev_b = 0; prev_a = 0;
        @(negedge clk); en = 1'b1;
        run_period(3, 2, 4, 1'b0, 1'b0, 12'h0);
        // drop en inside zero interval while sensing
        repeat (6) @(posedge clk);
        #2;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b10100, "R4");
        @(negedge clk); en = 1'b0; #1;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b00000, "R9");
        @(negedge clk); en = 1'b1;
        prev_s = 0; prev_b = 0; prev_a = 0;
        run_period(3, 2, 4, 1'b0, 1'b0, 12'h0);

        // R1: synchronous reset in the middle of ramp-down, en held high
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        chk({gate_a, gate_b, sense_en, peak_strobe, restart_strobe}, 5'b00000, "R1");
        @(negedge clk); rst = 1'b0;
        prev_s = 0; prev_b = 0; prev_a = 0;
        run_period(3, 2, 4, 1'b0, 1'b0, 12'h0);

        // R8: lengths changed mid-period apply only from the next period
        do_reset();
        up_len = 4'd2; down_len = 4'd2; zero_len = 4'd3;
        en = 1'b1;
        run_period(2, 2, 3, 1'b0, 1'b1, {4'd4, 4'd1, 4'd2});
        run_period(4, 1, 2, 1'b1, 1'b0, 12'h0);
        run_period(4, 1, 2, 1'b1, 1'b0, 12'h0);
        @(negedge clk); en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule